// File: doc/BRIEF.md
# Random Word Generator Register Front End

This block places a hardware random source behind a small synchronous register bus. Software turns generation on through a control register. It waits until a status flag says a fresh 32-bit word is waiting, then reads that word from a data register. The source delivers words on a valid/data stream and reports two fault levels: a seed fault, meaning the entropy looks degenerate, and a clock fault, meaning the source clock is out of range. The block tracks each fault as a live copy and as a latched copy. A data word is never offered while a seed fault is present.

At its centre is a four-state generator machine. `ST_IDLE` means generation is off. `ST_FILL` means it is waiting for a source word. `ST_HOLD` means a word is held and ready. `ST_HALT` means a seed fault has stopped generation. The transitions are named as follows:
- `start`: IDLE→FILL, taken when run is set.
- `capture`: FILL→HOLD, taken on a valid source word.
- `consume`: HOLD→FILL, taken on a data-register read.
- `trip`: FILL or HOLD→HALT, taken on a live seed fault, which also discards the held word.
- `stop`: any state→IDLE, taken when run is clear.

Only `stop` leaves HALT, so software must clear run and set it again to restart. One interrupt-enable bit passes the ready flag and both latched faults onto a single interrupt line.

Top module: `rng_regif`

Register addresses are word indices: 0 is control, 1 is status, 2 is data, and 3 is unmapped.
- Control: bit 0 is run, bit 1 is interrupt enable.
- Status: bit 0 is ready, bit 1 is live clock fault, bit 2 is live seed fault, bit 5 is latched clock fault, bit 6 is latched seed fault. All other bits read 0.

## Requirements
- R1: A write to address 0 loads run (bit 0) and interrupt enable (bit 1). A read of address 0 returns them in the same positions. `src_run` equals the stored run bit.
- R2: When run is set and a valid source word arrives while the machine waits for a word, that word is stored and status bit 0 (ready) reads 1. A read of address 2 returns the full 32-bit stored word.
- R3: A read of address 2 clears ready. A write to address 1 never clears ready, whatever value is written.
- R4: The live fault bits in status (bit 1 clock, bit 2 seed) follow the fault inputs one cycle later. Status bits 3, 4 and 7 and above always read 0.
- R5: A latched fault bit (bit 5 clock, bit 6 seed) sets on every cycle its live bit is 1. It is cleared by writing 0 to its position at address 1, and writing 1 leaves it unchanged. If a clear and a set land on the same cycle, the set wins.
- R6: `irq` equals interrupt enable AND (ready OR latched clock fault OR latched seed fault).
- R7: While the live seed fault is 1, no source word is stored. A held word is discarded: ready drops and the data register reads 0.
- R8: After a seed fault, generation stays stopped even once the fault input returns to 0. It restarts only after run is cleared and then set again.
- R9: A clock fault neither drops ready nor changes the held word.
- R10: A read returns its value on `reg_rdata` one cycle after the strobe, and `reg_rdata` keeps that value until the next read. A read of address 3 returns 0.
- R11: Clearing run returns the machine to idle with ready low. No source word is stored until run is set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 2 | Register word index |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| src_valid | input | 1 | Source word valid |
| src_word | input | 32 | Source word |
| src_seed_fault | input | 1 | Live seed fault from the source |
| src_clk_fault | input | 1 | Live clock fault from the source |
| src_run | output | 1 | Run request to the source |
| irq | output | 1 | Combined interrupt |

## Verification
Two pairs of events can collide in a single cycle.

The first pair is a data-register read and the `trip` transition. The bench raises the seed fault one cycle before reading a held word, so the machine sees the fault on the same edge as the read. The read must return the word as it stood before that edge, and the next status read must show ready low with the latched seed fault set.

The second pair is a latched-fault clear and a live fault that sets the same bit. The bench writes 0 to the status register while the clock fault input is held high. The latched bit must survive.

Both cases are also compared cycle by cycle against a behavioural model of the register file.

// File: rtl/rng_regif_pkg.sv
package rng_regif_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_HOLD = 2'd2,
        ST_HALT = 2'd3
    } gen_state_t;

    // Register word indices
    localparam int unsigned REG_CTRL = 0;
    localparam int unsigned REG_STAT = 1;
    localparam int unsigned REG_DATA = 2;

    // Control bit positions
    localparam int unsigned CTRL_RUN_BIT = 0;
    localparam int unsigned CTRL_IE_BIT  = 1;

    // Status bit positions; fault i sits at STAT_FAULT_BASE + i
    localparam int unsigned STAT_RDY_BIT    = 0;
    localparam int unsigned STAT_FAULT_BASE = 1;
    localparam int unsigned STICKY_SHIFT    = 4;

    // Fault indices
    localparam int unsigned FAULT_CLK  = 0;
    localparam int unsigned FAULT_SEED = 1;
    localparam int unsigned NUM_FAULT  = 2;

endpackage

// File: rtl/rng_fault_track.sv
module rng_fault_track
    import rng_regif_pkg::*;
#(
    parameter int unsigned N_FAULT = NUM_FAULT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_FAULT-1:0] fault_in,
    input  logic               clr_we,
    input  logic [N_FAULT-1:0] keep_mask,
    output logic [N_FAULT-1:0] cur_q,
    output logic [N_FAULT-1:0] sticky_q
);

    for (genvar g = 0; g < int'(N_FAULT); g++) begin : g_fault
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cur_q[g]    <= 1'b0;
                sticky_q[g] <= 1'b0;
            end else begin
                cur_q[g] <= fault_in[g];
                // a live fault outranks a software clear
                if (cur_q[g]) begin
                    sticky_q[g] <= 1'b1;
                end else if (clr_we) begin
                    sticky_q[g] <= sticky_q[g] & keep_mask[g];
                end
            end
        end
    end

endmodule

// File: rtl/rng_gen_fsm.sv
module rng_gen_fsm
    import rng_regif_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              seed_live,
    input  logic              word_valid,
    input  logic [DATA_W-1:0] word_in,
    input  logic              word_take,
    output logic              ready,
    output logic [DATA_W-1:0] word_q
);

    gen_state_t state_q, state_d;
    logic       do_capture;
    logic       do_discard;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: stop, start, capture, consume, trip
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (run) state_d = ST_FILL;
            end
            ST_FILL: begin
                if (!run)           state_d = ST_IDLE;
                else if (seed_live) state_d = ST_HALT;
                else if (word_valid) state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (!run)           state_d = ST_IDLE;
                else if (seed_live) state_d = ST_HALT;
                else if (word_take) state_d = ST_FILL;
            end
            ST_HALT: begin
                if (!run) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign do_capture = (state_q == ST_FILL) && run && !seed_live && word_valid;
    assign do_discard = (state_q == ST_HOLD) && run && seed_live;

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (do_capture) begin
            word_q <= word_in;
        end else if (do_discard) begin
            word_q <= '0;
        end
    end

    assign ready = (state_q == ST_HOLD);

endmodule

// File: rtl/rng_bus_regs.sv
module rng_bus_regs
    import rng_regif_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ADDR_W  = 2,
    parameter int unsigned N_FAULT = NUM_FAULT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               wr,
    input  logic               rd,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    input  logic               ready,
    input  logic [N_FAULT-1:0] cur,
    input  logic [N_FAULT-1:0] sticky,
    input  logic [DATA_W-1:0]  word,
    output logic               run,
    output logic               ie,
    output logic               stat_we,
    output logic [N_FAULT-1:0] keep_mask,
    output logic               word_take
);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(REG_CTRL);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(REG_STAT);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(REG_DATA);

    logic [DATA_W-1:0] ctrl_word;
    logic [DATA_W-1:0] stat_word;
    logic [DATA_W-1:0] rd_mux;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0;
            ie  <= 1'b0;
        end else if (wr && addr == A_CTRL) begin
            run <= wdata[CTRL_RUN_BIT];
            ie  <= wdata[CTRL_IE_BIT];
        end
    end

    assign stat_we   = wr && (addr == A_STAT);
    assign word_take = rd && (addr == A_DATA);

    for (genvar g = 0; g < int'(N_FAULT); g++) begin : g_keep
        assign keep_mask[g] = wdata[STAT_FAULT_BASE + g + STICKY_SHIFT];
    end

    always_comb begin
        ctrl_word = '0;
        ctrl_word[CTRL_RUN_BIT] = run;
        ctrl_word[CTRL_IE_BIT]  = ie;
        stat_word = '0;
        stat_word[STAT_RDY_BIT] = ready;
        for (int i = 0; i < int'(N_FAULT); i++) begin
            stat_word[STAT_FAULT_BASE + i]                = cur[i];
            stat_word[STAT_FAULT_BASE + i + STICKY_SHIFT] = sticky[i];
        end
    end

    always_comb begin
        unique case (addr)
            A_CTRL:  rd_mux = ctrl_word;
            A_STAT:  rd_mux = stat_word;
            A_DATA:  rd_mux = word;
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd) begin
            rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/rng_regif.sv
module rng_regif
    import rng_regif_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              src_valid,
    input  logic [DATA_W-1:0] src_word,
    input  logic              src_seed_fault,
    input  logic              src_clk_fault,
    output logic              src_run,
    output logic              irq
);

    logic                 run;
    logic                 ie;
    logic                 ready;
    logic                 stat_we;
    logic                 word_take;
    logic [DATA_W-1:0]    word_q;
    logic [NUM_FAULT-1:0] fault_in;
    logic [NUM_FAULT-1:0] keep_mask;
    logic [NUM_FAULT-1:0] cur;
    logic [NUM_FAULT-1:0] sticky;

    assign fault_in[FAULT_CLK]  = src_clk_fault;
    assign fault_in[FAULT_SEED] = src_seed_fault;

    rng_bus_regs #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .N_FAULT(NUM_FAULT)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (reg_addr),
        .wr       (reg_wr),
        .rd       (reg_rd),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .ready    (ready),
        .cur      (cur),
        .sticky   (sticky),
        .word     (word_q),
        .run      (run),
        .ie       (ie),
        .stat_we  (stat_we),
        .keep_mask(keep_mask),
        .word_take(word_take)
    );

    rng_fault_track #(
        .N_FAULT(NUM_FAULT)
    ) u_faults (
        .clk      (clk),
        .rst_n    (rst_n),
        .fault_in (fault_in),
        .clr_we   (stat_we),
        .keep_mask(keep_mask),
        .cur_q    (cur),
        .sticky_q (sticky)
    );

    rng_gen_fsm #(
        .DATA_W(DATA_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .seed_live (cur[FAULT_SEED]),
        .word_valid(src_valid),
        .word_in   (src_word),
        .word_take (word_take),
        .ready     (ready),
        .word_q    (word_q)
    );

    assign src_run = run;
    assign irq     = ie && (ready || (|sticky));

endmodule

// File: rtl/rng_regif_chk.sv
module rng_regif_chk #(
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic              ie,
    input logic              ready,
    input logic [DATA_W-1:0] word_q,
    input logic              seed_cur,
    input logic              clk_cur,
    input logic              seed_st,
    input logic              clk_st,
    input logic              stat_we,
    input logic              word_take,
    input logic              src_valid,
    input logic              irq
);

    // R2
    ready_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(src_valid));

    // R3
    ready_wr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready && stat_we && !word_take && !seed_cur && run |=> ready);

    // R5
    seed_st_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(seed_st) |-> $past(stat_we));

    // R5
    clk_st_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_st) |-> $past(stat_we));

    // R6
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ie);

    // R7
    seed_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready && seed_cur |=> !ready);

    // R9
    clk_fault_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready && clk_cur && !seed_cur && !word_take && run |=> ready && $stable(word_q));

    // R11
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !ready);

endmodule

bind rng_regif rng_regif_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .ie       (ie),
    .ready    (ready),
    .word_q   (word_q),
    .seed_cur (cur[1]),
    .clk_cur  (cur[0]),
    .seed_st  (sticky[1]),
    .clk_st   (sticky[0]),
    .stat_we  (stat_we),
    .word_take(word_take),
    .src_valid(src_valid),
    .irq      (irq)
);

// File: tb/rng_regif_bench.sv
module rng_regif_bench;

    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    reg_addr = '0;
    logic          reg_wr = 1'b0;
    logic          reg_rd = 1'b0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          src_valid = 1'b0;
    logic [DW-1:0] src_word = '0;
    logic          src_seed_fault = 1'b0;
    logic          src_clk_fault = 1'b0;
    logic          src_run;
    logic          irq;

    int    n_checks = 0;
    int    n_errors = 0;
    bit    done = 0;
    string phase = "R1";

    always #10 clk = ~clk;

    rng_regif u_rng_regif (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .src_valid(src_valid), .src_word(src_word),
        .src_seed_fault(src_seed_fault), .src_clk_fault(src_clk_fault),
        .src_run(src_run), .irq(irq)
    );

    // behavioural reference: 0 idle, 1 wait word, 2 holding, 3 halted
    int            m_st;
    bit            m_run, m_ie, m_ccur, m_scur, m_cst, m_sst;
    logic [DW-1:0] m_word, m_rdata;

    function automatic logic [DW-1:0] m_status();
        logic [DW-1:0] s = '0;
        s[0] = (m_st == 2);
        s[1] = m_ccur;
        s[2] = m_scur;
        s[5] = m_cst;
        s[6] = m_sst;
        return s;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_run = 0; m_ie = 0; m_ccur = 0; m_scur = 0;
            m_cst = 0; m_sst = 0; m_word = '0; m_rdata = '0;
        end else begin
            bit n_run = m_run, n_ie = m_ie, n_cst, n_sst;
            int n_st = m_st;
            logic [DW-1:0] n_word = m_word;
            if (reg_rd) begin
                case (reg_addr)
                    2'd0: m_rdata = {30'd0, m_ie, m_run};
                    2'd1: m_rdata = m_status();
                    2'd2: m_rdata = m_word;
                    default: m_rdata = '0;
                endcase
            end
            if (reg_wr && reg_addr == 2'd0) begin
                n_run = reg_wdata[0];
                n_ie  = reg_wdata[1];
            end
            n_cst = m_ccur ? 1'b1 : ((reg_wr && reg_addr == 2'd1) ? (m_cst & reg_wdata[5]) : m_cst);
            n_sst = m_scur ? 1'b1 : ((reg_wr && reg_addr == 2'd1) ? (m_sst & reg_wdata[6]) : m_sst);
            if (!m_run) n_st = 0;
            else if (m_st == 0) n_st = 1;
            else if (m_st == 1) begin
                if (m_scur) n_st = 3;
                else if (src_valid) begin n_st = 2; n_word = src_word; end
            end else if (m_st == 2) begin
                if (m_scur) begin n_st = 3; n_word = '0; end
                else if (reg_rd && reg_addr == 2'd2) n_st = 1;
            end
            m_st = n_st; m_word = n_word; m_run = n_run; m_ie = n_ie;
            m_cst = n_cst; m_sst = n_sst;
            m_ccur = src_clk_fault; m_scur = src_seed_fault;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(irq === (m_ie && (m_st == 2 || m_cst || m_sst)), "R6", "irq model",
                  DW'(irq), DW'(m_ie && (m_st == 2 || m_cst || m_sst)));
            check(src_run === m_run, "R1", "src_run model", DW'(src_run), DW'(m_run));
            check(reg_rdata === m_rdata, phase, "rdata model", reg_rdata, m_rdata);
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [DW-1:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic bus_read_chk(input logic [1:0] a, input logic [DW-1:0] exp, input string req);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        check(reg_rdata === exp, req, "read", reg_rdata, exp);
    endtask

    task automatic feed(input logic [DW-1:0] w, input int n);
        src_word = w; src_valid = 1'b1;
        tick(n);
        src_valid = 1'b0;
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        phase = "R1";
        bus_read_chk(2'd0, 32'h0, "R1");
        phase = "R4";
        bus_read_chk(2'd1, 32'h0, "R4");
        check(irq === 1'b0, "R6", "irq after reset", DW'(irq), 0);

        phase = "R2";
        bus_write(2'd0, 32'h3);
        bus_read_chk(2'd0, 32'h3, "R1");
        feed(32'hA5A5_0001, 4);
        bus_read_chk(2'd1, 32'h1, "R2");
        check(irq === 1'b1, "R6", "irq on ready", DW'(irq), 1);
        phase = "R3";
        bus_write(2'd1, 32'h0);
        bus_read_chk(2'd1, 32'h1, "R3");
        bus_read_chk(2'd2, 32'hA5A5_0001, "R2");
        bus_read_chk(2'd1, 32'h0, "R3");
        check(irq === 1'b0, "R6", "irq after read", DW'(irq), 0);

        phase = "R9";
        fork
            feed(32'hC0DE_1234, 3);
            begin src_clk_fault = 1'b1; tick(2); src_clk_fault = 1'b0; end
        join
        tick(3);
        bus_read_chk(2'd1, 32'h21, "R9");
        bus_read_chk(2'd2, 32'hC0DE_1234, "R9");
        phase = "R5";
        bus_read_chk(2'd1, 32'h20, "R5");
        bus_write(2'd1, 32'hFFFF_FFFF);
        bus_read_chk(2'd1, 32'h20, "R5");
        bus_write(2'd1, 32'h0);
        bus_read_chk(2'd1, 32'h0, "R5");

        phase = "R7";
        feed(32'h1357_9BDF, 3);
        src_seed_fault = 1'b1;
        tick(3);
        bus_read_chk(2'd1, 32'h44, "R7");
        check(irq === 1'b1, "R6", "irq on seed latch", DW'(irq), 1);
        src_seed_fault = 1'b0;
        tick(2);
        feed(32'hDEAD_BEEF, 3);
        phase = "R8";
        bus_read_chk(2'd1, 32'h40, "R8");
        bus_read_chk(2'd2, 32'h0, "R7");
        bus_write(2'd1, 32'h0);
        bus_read_chk(2'd1, 32'h0, "R5");
        bus_write(2'd0, 32'h2);
        bus_write(2'd0, 32'h3);
        feed(32'h0BAD_F00D, 4);
        bus_read_chk(2'd1, 32'h1, "R8");
        bus_read_chk(2'd2, 32'h0BAD_F00D, "R8");

        phase = "R5";
        src_clk_fault = 1'b1;
        tick(2);
        bus_write(2'd1, 32'h0);
        src_clk_fault = 1'b0;
        tick(2);
        bus_read_chk(2'd1, 32'h20, "R5");
        bus_write(2'd1, 32'h0);
        bus_read_chk(2'd1, 32'h0, "R5");

        phase = "R7";
        feed(32'h2468_ACE0, 3);
        src_seed_fault = 1'b1;
        tick(1);
        bus_read_chk(2'd2, 32'h2468_ACE0, "R7");
        src_seed_fault = 1'b0;
        tick(1);
        bus_read_chk(2'd1, 32'h40, "R7");
        bus_write(2'd0, 32'h2);
        bus_write(2'd0, 32'h3);
        bus_write(2'd1, 32'h0);

        phase = "R10";
        bus_read_chk(2'd3, 32'h0, "R10");
        tick(2);
        check(reg_rdata === 32'h0, "R10", "rdata held", reg_rdata, 0);

        phase = "R11";
        feed(32'h7777_1111, 3);
        check(irq === 1'b1, "R6", "irq ready", DW'(irq), 1);
        bus_write(2'd0, 32'h1);
        check(irq === 1'b0, "R6", "irq masked", DW'(irq), 0);
        bus_write(2'd0, 32'h0);
        tick(1);
        bus_read_chk(2'd1, 32'h0, "R11");
        feed(32'h9999_2222, 3);
        bus_read_chk(2'd1, 32'h0, "R11");
        bus_read_chk(2'd0, 32'h0, "R1");

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule